// File: doc/BRIEF.md
# Shift Unit with Result Flags

This block performs the four shift operations of a compact 16-bit instruction set on a 32-bit operand: logical left, logical right, arithmetic right and rotate right. The amount comes either from a 5-bit immediate field or from the low byte of a register. The block returns the shifted value together with negative, zero and carry flags. It applies the edge rules that matter to software, namely amounts of zero, amounts that equal the data width and amounts above it. An immediate zero on a right shift is taken as a full-width shift.

Each request is presented for one cycle with `in_valid`. The result and the flags are captured in an output stage that has two states. `OS_IDLE` means no result is presented. `OS_LOADED` means `result` and the flags hold the outcome of the request accepted on the previous edge. The stage moves IDLE→LOADED when `in_valid` is high (load). It moves LOADED→IDLE when `in_valid` is low (drain). It stays LOADED on back-to-back requests (reload). Once the stage leaves LOADED, the outputs keep their last values.

Top module: `shf_unit`

## Requirements
- R1: `amount` is an 8-bit unsigned value, and all 256 register amounts are handled. With `use_imm`=1 only `amount[4:0]` is used and bits 7:5 are ignored.
- R2: A register amount of 0 passes the operand through unchanged for every `shift_kind`. C keeps `carry_in`, and N and Z follow the result.
- R3: For amounts 1–31, shift kind 0 (LSL) gives operand<<n with C = operand bit (32−n). Kind 1 (LSR) gives a zero-filled operand>>n with C = operand bit (n−1). Kind 2 (ASR) gives a sign-filled operand>>n with C = operand bit (n−1).
- R4: A shift by exactly 32 gives result 0 for both LSL and LSR. C is operand bit 0 for LSL and operand bit 31 for LSR.
- R5: LSL or LSR by more than 32 gives result 0 with C=0, N=0 and Z=1.
- R6: ASR by 32 or more fills every result bit with operand bit 31, and C equals operand bit 31.
- R7: With `use_imm`=1, an immediate of 0 for LSR or ASR acts as a shift by 32.
- R8: With `use_imm`=1, an immediate of 0 for LSL or for ROR (kind 3) is a plain move: the result is the operand and C keeps `carry_in`.
- R9: ROR (kind 3) by a nonzero amount rotates by the amount modulo 32. A rotation of 0 leaves the operand unchanged with C = bit 31. Any other rotation r gives C = operand bit (r−1).
- R10: N always equals result bit 31, and Z is 1 exactly when the 32-bit result is zero.
- R11: After reset `out_valid`, `result` and all flags are 0. A request with `in_valid`=1 appears on the outputs with `out_valid`=1 one clock later. A cycle without `in_valid` drops `out_valid` on the next edge and holds `result` and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Value to shift |
| amount | input | 8 | Register amount, or immediate in bits 4:0 |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| use_imm | input | 1 | 1 selects the immediate amount |
| carry_in | input | 1 | Carry flag before the operation |
| out_valid | output | 1 | Result present (stage in OS_LOADED) |
| result | output | 32 | Shifted value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
A wrong amount class, such as confusing exactly-32 with above-32 or missing the immediate-zero substitution, shows up on `flag_c` and `result` on the output edge right after the request, because only one register sits on the path. A stuck or wrong output state shows as `out_valid` failing to rise or fall on the edge after `in_valid` changes. A stray load shows as a result that changes during an idle cycle. Carry-bit index errors appear only with operands whose neighbouring bits differ, so the bench uses such patterns at amounts 1, 31, 32, 33 and 255.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        AC_ZERO = 2'd0,
        AC_PART = 2'd1,
        AC_FULL = 2'd2,
        AC_OVER = 2'd3
    } amt_class_e;

    typedef enum logic {
        OS_IDLE   = 1'b0,
        OS_LOADED = 1'b1
    } out_state_e;

endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 5
) (
    input  logic [REG_AMT_W-1:0] amount,
    input  shift_kind_e          kind,
    input  logic                 use_imm,
    output logic [REG_AMT_W-1:0] amt_eff,
    output amt_class_e           cls
);
    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);
    localparam int PAD_W = REG_AMT_W - IMM_W;

    logic [IMM_W-1:0] imm_val;
    logic             imm_is_zero;
    logic             right_kind;

    assign imm_val     = amount[IMM_W-1:0];
    assign imm_is_zero = (imm_val == '0);
    assign right_kind  = (kind == SK_LSR) || (kind == SK_ASR);

    always_comb begin
        if (use_imm) begin
            if (imm_is_zero && right_kind) begin
                amt_eff = FULL_AMT;
            end else begin
                amt_eff = {{PAD_W{1'b0}}, imm_val};
            end
        end else begin
            amt_eff = amount;
        end
    end

    always_comb begin
        if (amt_eff == '0) begin
            cls = AC_ZERO;
        end else if (amt_eff < FULL_AMT) begin
            cls = AC_PART;
        end else if (amt_eff == FULL_AMT) begin
            cls = AC_FULL;
        end else begin
            cls = AC_OVER;
        end
    end

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8
) (
    input  logic [DATA_W-1:0]    operand,
    input  shift_kind_e          kind,
    input  logic [REG_AMT_W-1:0] amt_eff,
    input  amt_class_e           cls,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    res,
    output logic                 n_out,
    output logic                 z_out,
    output logic                 c_out
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W:0]     lsl_ext;
    logic [DATA_W:0]     lsr_ext;
    logic [DATA_W:0]     asr_ext;
    logic [SH_W-1:0]     rot;
    logic [2*DATA_W-1:0] rot_dbl;
    logic [DATA_W:0]     rot_ext;
    logic                msb;

    assign msb     = operand[DATA_W-1];
    assign lsl_ext = {1'b0, operand} << amt_eff;
    assign lsr_ext = {operand, 1'b0} >> amt_eff;
    assign asr_ext = $unsigned($signed({operand, 1'b0}) >>> amt_eff);
    assign rot     = amt_eff[SH_W-1:0];
    assign rot_dbl = {operand, operand} >> rot;
    assign rot_ext = {operand, 1'b0} >> rot;

    always_comb begin
        res   = operand;
        c_out = carry_in;
        if (cls != AC_ZERO) begin
            unique case (kind)
                SK_LSL: begin
                    unique case (cls)
                        AC_PART: begin
                            res   = lsl_ext[DATA_W-1:0];
                            c_out = lsl_ext[DATA_W];
                        end
                        AC_FULL: begin
                            res   = '0;
                            c_out = operand[0];
                        end
                        default: begin
                            res   = '0;
                            c_out = 1'b0;
                        end
                    endcase
                end
                SK_LSR: begin
                    unique case (cls)
                        AC_PART: begin
                            res   = lsr_ext[DATA_W:1];
                            c_out = lsr_ext[0];
                        end
                        AC_FULL: begin
                            res   = '0;
                            c_out = msb;
                        end
                        default: begin
                            res   = '0;
                            c_out = 1'b0;
                        end
                    endcase
                end
                SK_ASR: begin
                    if (cls == AC_PART) begin
                        res   = asr_ext[DATA_W:1];
                        c_out = asr_ext[0];
                    end else begin
                        res   = {DATA_W{msb}};
                        c_out = msb;
                    end
                end
                SK_ROR: begin
                    if (rot == '0) begin
                        res   = operand;
                        c_out = msb;
                    end else begin
                        res   = rot_dbl[DATA_W-1:0];
                        c_out = rot_ext[0];
                    end
                end
                default: begin
                    res   = operand;
                    c_out = carry_in;
                end
            endcase
        end
    end

    assign n_out = res[DATA_W-1];
    assign z_out = (res == '0);

endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d_res,
    input  logic              d_n,
    input  logic              d_z,
    input  logic              d_c,
    input  logic [DATA_W-1:0] chk_operand,
    input  logic              chk_carry,
    input  amt_class_e        chk_cls,
    input  shift_kind_e       chk_kind,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c
);
    out_state_e state_q;
    out_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE:   state_d = in_valid ? OS_LOADED : OS_IDLE;
            OS_LOADED: state_d = in_valid ? OS_LOADED : OS_IDLE;
            default:   state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else if (in_valid) begin
            result <= d_res;
            flag_n <= d_n;
            flag_z <= d_z;
            flag_c <= d_c;
        end
    end

    assign out_valid = (state_q == OS_LOADED);

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c))); // R11
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_cls == AC_ZERO) |=>
        (result == $past(chk_operand) && flag_c == $past(chk_carry))); // R2
    AST_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_cls == AC_OVER && (chk_kind == SK_LSL || chk_kind == SK_LSR)) |=>
        (result == '0 && !flag_c && !flag_n && flag_z)); // R5
    AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_kind == SK_ASR && (chk_cls == AC_FULL || chk_cls == AC_OVER)) |=>
        (result == {DATA_W{$past(chk_operand[DATA_W-1])}} &&
         flag_c == $past(chk_operand[DATA_W-1]))); // R6
    AST_N_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == result[DATA_W-1])); // R10
    AST_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0))); // R10

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    operand,
    input  logic [REG_AMT_W-1:0] amount,
    input  logic [1:0]           shift_kind,
    input  logic                 use_imm,
    input  logic                 carry_in,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_c
);
    shift_kind_e          kind;
    logic [REG_AMT_W-1:0] amt_eff;
    amt_class_e           cls;
    logic [DATA_W-1:0]    dp_res;
    logic                 dp_n;
    logic                 dp_z;
    logic                 dp_c;

    assign kind = shift_kind_e'(shift_kind);

    shf_amount_sel #(
        .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W), .IMM_W(IMM_W)
    ) u_amt (
        .amount(amount), .kind(kind), .use_imm(use_imm),
        .amt_eff(amt_eff), .cls(cls)
    );

    shf_datapath #(
        .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)
    ) u_dp (
        .operand(operand), .kind(kind), .amt_eff(amt_eff), .cls(cls),
        .carry_in(carry_in), .res(dp_res), .n_out(dp_n), .z_out(dp_z),
        .c_out(dp_c)
    );

    shf_out_stage #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .d_res(dp_res), .d_n(dp_n), .d_z(dp_z), .d_c(dp_c),
        .chk_operand(operand), .chk_carry(carry_in), .chk_cls(cls),
        .chk_kind(kind), .out_valid(out_valid), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [7:0]  amount = '0;
    logic [1:0]  shift_kind = '0;
    logic        use_imm = 1'b0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    shf_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .amount(amount), .shift_kind(shift_kind), .use_imm(use_imm),
        .carry_in(carry_in), .out_valid(out_valid), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic logic [34:0] expect_op(input logic [31:0] op, input logic [7:0] am,
                                              input logic [1:0] k, input logic imm,
                                              input logic cin);
        int a;
        int r_amt;
        logic [31:0] r;
        logic c;
        a = imm ? int'(am[4:0]) : int'(am);
        if (imm && a == 0 && (k == 2'd1 || k == 2'd2)) a = 32;
        r = op;
        c = cin;
        if (a != 0) begin
            case (k)
                2'd0: if (a < 32) begin r = op << a; c = op[32-a]; end
                      else if (a == 32) begin r = '0; c = op[0]; end
                      else begin r = '0; c = 1'b0; end
                2'd1: if (a < 32) begin r = op >> a; c = op[a-1]; end
                      else if (a == 32) begin r = '0; c = op[31]; end
                      else begin r = '0; c = 1'b0; end
                2'd2: if (a < 32) begin r = $unsigned($signed(op) >>> a); c = op[a-1]; end
                      else begin r = {32{op[31]}}; c = op[31]; end
                default: begin
                    r_amt = a % 32;
                    if (r_amt == 0) c = op[31];
                    else begin r = (op >> r_amt) | (op << (32 - r_amt)); c = op[r_amt-1]; end
                end
            endcase
        end
        return {r, r[31], (r == 32'd0), c};
    endfunction

    task automatic check(input string tag, input logic ok, input logic [63:0] got,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] op, input logic [7:0] am,
                          input logic [1:0] k, input logic imm, input logic cin);
        logic [34:0] e;
        logic [34:0] g;
        e = expect_op(op, am, k, imm, cin);
        @(negedge clk);
        operand = op; amount = am; shift_kind = k; use_imm = imm; carry_in = cin;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        g = {result, flag_n, flag_z, flag_c};
        check({tag, " R11 valid"}, out_valid === 1'b1, 64'(out_valid), 64'd1);
        check(tag, g === e, 64'(g), 64'(e));
    endtask

    task automatic run_lit(input string tag, input logic [31:0] op, input logic [7:0] am,
                           input logic [1:0] k, input logic imm, input logic cin,
                           input logic [31:0] er, input logic ec);
        @(negedge clk);
        operand = op; amount = am; shift_kind = k; use_imm = imm; carry_in = cin;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result === er && flag_c === ec, {31'd0, result, flag_c}, {31'd0, er, ec});
    endtask

    task automatic t_reset();
        check("R11 reset", {out_valid, result, flag_n, flag_z, flag_c} === 36'd0,
              64'({out_valid, result, flag_n, flag_z, flag_c}), 64'd0);
    endtask

    task automatic t_imm_mask();
        run_op("R1 imm upper bits ignored", 32'h8000_0005, 8'hE3, 2'd1, 1'b1, 1'b0);
        run_lit("R1 imm E3 as 3", 32'h0000_0010, 8'hE3, 2'd0, 1'b1, 1'b0, 32'h0000_0080, 1'b0);
        run_op("R1 reg 255 lsl", 32'hFFFF_FFFF, 8'hFF, 2'd0, 1'b0, 1'b1);
        run_op("R1 reg 200 ror", 32'h1234_5678, 8'd200, 2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_reg_zero();
        for (int k = 0; k < 4; k++) begin
            run_op("R2 reg zero c1", 32'h8000_0000, 8'd0, 2'(k), 1'b0, 1'b1);
            run_op("R2 reg zero c0", 32'h0000_0000, 8'd0, 2'(k), 1'b0, 1'b0);
        end
    endtask

    task automatic t_partial();
        run_lit("R3 lsl 1", 32'h8000_0001, 8'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0002, 1'b1);
        run_lit("R3 asr 4", 32'hF000_0008, 8'd4, 2'd2, 1'b0, 1'b1, 32'hFF00_0000, 1'b1);
        foreach (amts[i]) ;
        for (int a = 1; a < 32; a += 5) begin
            run_op("R3 lsl", 32'hA5C3_0F96, 8'(a), 2'd0, 1'b0, 1'b0);
            run_op("R3 lsr", 32'h5A3C_F069, 8'(a), 2'd1, 1'b0, 1'b1);
            run_op("R3 asr", 32'hA5C3_0F96, 8'(a), 2'd2, 1'b0, 1'b0);
        end
        run_op("R3 lsr 31", 32'h8000_0000, 8'd31, 2'd1, 1'b0, 1'b0);
        run_op("R3 lsl 31", 32'h0000_0003, 8'd31, 2'd0, 1'b0, 1'b0);
    endtask

    int amts[1];

    task automatic t_exact32();
        run_lit("R4 lsl 32", 32'h0000_0001, 8'd32, 2'd0, 1'b0, 1'b0, 32'd0, 1'b1);
        run_lit("R4 lsr 32", 32'h8000_0000, 8'd32, 2'd1, 1'b0, 1'b0, 32'd0, 1'b1);
        run_op("R4 lsr 32 b31 clear", 32'h7FFF_FFFF, 8'd32, 2'd1, 1'b0, 1'b1);
    endtask

    task automatic t_over();
        run_op("R5 lsl 33", 32'hFFFF_FFFF, 8'd33, 2'd0, 1'b0, 1'b1);
        run_op("R5 lsr 33", 32'hFFFF_FFFF, 8'd33, 2'd1, 1'b0, 1'b1);
        run_lit("R5 lsr 100", 32'hFFFF_FFFF, 8'd100, 2'd1, 1'b0, 1'b1, 32'd0, 1'b0);
    endtask

    task automatic t_asr_big();
        run_op("R6 asr 32 neg", 32'h8000_0000, 8'd32, 2'd2, 1'b0, 1'b0);
        run_op("R6 asr 40 pos", 32'h7FFF_FFFF, 8'd40, 2'd2, 1'b0, 1'b1);
        run_lit("R6 asr 255", 32'h9000_0000, 8'd255, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_imm_right_zero();
        run_lit("R7 imm lsr 0", 32'h8000_0001, 8'd0, 2'd1, 1'b1, 1'b0, 32'd0, 1'b1);
        run_lit("R7 imm asr 0", 32'h8000_0001, 8'd0, 2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1);
        run_op("R7 imm asr 0 pos", 32'h4000_0001, 8'h20, 2'd2, 1'b1, 1'b1);
    endtask

    task automatic t_imm_lsl_zero();
        run_lit("R8 imm lsl 0", 32'h8765_4321, 8'd0, 2'd0, 1'b1, 1'b1, 32'h8765_4321, 1'b1);
        run_lit("R8 imm ror 0", 32'h8765_4321, 8'd0, 2'd3, 1'b1, 1'b0, 32'h8765_4321, 1'b0);
    endtask

    task automatic t_ror();
        run_lit("R9 ror 4", 32'h0000_000F, 8'd4, 2'd3, 1'b0, 1'b0, 32'hF000_0000, 1'b1);
        run_lit("R9 ror 32", 32'h8000_0001, 8'd32, 2'd3, 1'b0, 1'b0, 32'h8000_0001, 1'b1);
        run_op("R9 ror 64", 32'h7000_0001, 8'd64, 2'd3, 1'b0, 1'b1);
        run_op("R9 ror 33", 32'h0000_0002, 8'd33, 2'd3, 1'b0, 1'b1);
        run_op("R9 ror 17", 32'hDEAD_BEEF, 8'd17, 2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_flags();
        run_op("R10 zero result", 32'h0000_0001, 8'd1, 2'd1, 1'b0, 1'b0);
        run_op("R10 negative", 32'h4000_0000, 8'd1, 2'd0, 1'b0, 1'b0);
        run_op("R10 imm ror", 32'h0000_0001, 8'd1, 2'd3, 1'b1, 1'b0);
    endtask

    task automatic t_latency();
        logic [31:0] held;
        logic [2:0]  hf;
        run_op("R11 load", 32'h1111_0000, 8'd4, 2'd1, 1'b0, 1'b0);
        held = result;
        hf = {flag_n, flag_z, flag_c};
        @(negedge clk);
        operand = 32'hFFFF_FFFF; amount = 8'd1;
        @(negedge clk);
        check("R11 idle drop", out_valid === 1'b0, 64'(out_valid), 64'd0);
        check("R11 hold", {result, flag_n, flag_z, flag_c} === {held, hf},
              64'({result, flag_n, flag_z, flag_c}), 64'({held, hf}));
        @(negedge clk);
        operand = 32'h0000_0003; amount = 8'd1; shift_kind = 2'd0; use_imm = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R11 back1", out_valid === 1'b1 && result === 32'h6, 64'(result), 64'h6);
        operand = 32'h0000_0003; amount = 8'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 back2", out_valid === 1'b1 && result === 32'hC, 64'(result), 64'hC);
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        amts[0] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm_mask();
        t_reg_zero();
        t_partial();
        t_exact32();
        t_over();
        t_asr_big();
        t_imm_right_zero();
        t_imm_lsl_zero();
        t_ror();
        t_flags();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule